// File: doc/BRIEF.md
# Reciprocal-Multiply DCT Coefficient Quantizer

This block quantizes DCT coefficients without a divider. It keeps, for each of three colour components, 64 fixed-point reciprocals of the quantization steps, in zigzag order and with 19 fractional bits (2^19 / step). An encoded coefficient is multiplied by the matching reciprocal, rounded and shifted. The result is then clamped to a 12-bit signed range. Each coefficient arrives with its component number and its zigzag index. Results leave in arrival order with the same tags.

Software fills the table through a three-register write port: a mode word, an address word and a data word. Writing a mode word whose two low bits are both set moves the controller from state ST_ENCODE to state ST_LOAD (transition "arm"). In ST_LOAD each data write stores one reciprocal and advances the address. Writing a mode word with any other low bits returns the controller to ST_ENCODE (transition "disarm"). The coefficient input stalls while the controller is in ST_LOAD. Component c occupies word addresses c*64 to c*64+63. Components 1 and 2 are normally loaded with the same chroma reciprocals, and component 0 with the luma reciprocals.

Top module: `recip_quantizer`

## Requirements
- R1: A write with cfg_sel=0 (mode) whose cfg_wdata[1:0] is 2'b11 puts the block in load mode from the next cycle. A mode write with any other value of those bits leaves load mode from the next cycle. The other mode bits carry no function.
- R2: A write with cfg_sel=1 sets the load address to cfg_wdata[7:0], in either mode. Table word c*64+z holds the reciprocal used for component c, zigzag index z.
- R3: In load mode, a write with cfg_sel=2 stores cfg_wdata[19:0] at the load address and then increments the address by one. A data write at an address of 192 or more stores nothing, but it still increments the address.
- R4: A data write (cfg_sel=2) outside load mode changes neither the table nor the address. A write with cfg_sel=3 has no effect.
- R5: For coefficient x and stored reciprocal r, the result is sign(x) * ((|x|*r + 2^18) >> 19), which rounds halves away from zero.
- R6: The result magnitude saturates at 2047, so out_coef stays within -2047..+2047.
- R7: One coefficient can be accepted per cycle. A coefficient accepted at clock edge k appears on out_valid/out_coef/out_comp/out_idx right after edge k+1, with its component and index tags unchanged. out_valid is low in every other cycle.
- R8: in_ready is low exactly while in load mode. While it is low, in_valid produces no output.
- R9: A coefficient tagged with component 3 quantizes to 0.
- R10: After reset the block is in encode mode (in_ready high, out_valid low), and all table words are zero, so coefficients quantize to 0 until the table is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 address, 2 data, 3 none |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Coefficient valid |
| in_ready | output | 1 | Coefficient accepted when high with in_valid |
| in_coef | input | 16 | Signed DCT coefficient |
| in_comp | input | 2 | Component tag |
| in_idx | input | 6 | Zigzag index tag |
| out_valid | output | 1 | Result valid |
| out_coef | output | 12 | Signed quantized result |
| out_comp | output | 2 | Component tag of the result |
| out_idx | output | 6 | Zigzag index tag of the result |

## Verification
The hardest case to reach from the ports is a data write at the top edge of the table: writes at address 192 and above must be dropped while the address keeps counting. The bench loads words 190 and 191 and then one more word, and reads the neighbouring entries back through quantization to confirm that nothing else was disturbed. Exact rounding halves and the saturation edge need a step of 1 and a step of 2 at known indices. The load sequence plants these steps, and the bench then feeds ±half-step coefficients and extreme coefficients back to back. A reference model predicts every output cycle, so any stall or reordering shows up as a mismatch.

// File: rtl/qz_pkg.sv
package qz_pkg;
    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ST_ENCODE = 1'b0,
        ST_LOAD   = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/qz_cfg_fsm.sv
module qz_cfg_fsm
    import qz_pkg::*;
#(
    parameter int DEPTH   = 192,
    parameter int ADDR_W  = 8,
    parameter int RECIP_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic               load_active,
    output logic               tab_we,
    output logic [ADDR_W-1:0]  tab_waddr,
    output logic [RECIP_W-1:0] tab_wdata
);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

    cfg_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    cfg_sel_e          sel;
    logic              mode_wr, addr_wr, data_wr, arm_code;

    assign sel      = cfg_sel_e'(cfg_sel);
    assign mode_wr  = cfg_we && (sel == SEL_MODE);
    assign addr_wr  = cfg_we && (sel == SEL_ADDR);
    assign data_wr  = cfg_we && (sel == SEL_DATA);
    assign arm_code = (cfg_wdata[1:0] == 2'b11);

    // next-state: arm / disarm transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ENCODE: if (mode_wr && arm_code)  state_d = ST_LOAD;
            ST_LOAD:   if (mode_wr && !arm_code) state_d = ST_ENCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ENCODE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (addr_wr)
            addr_q <= cfg_wdata[ADDR_W-1:0];
        else if (data_wr && state_q == ST_LOAD)
            addr_q <= addr_q + 1'b1;
    end

    // outputs
    always_comb begin
        load_active = (state_q == ST_LOAD);
        tab_we      = data_wr && (state_q == ST_LOAD) && ({1'b0, addr_q} < DEPTH_L);
        tab_waddr   = addr_q;
        tab_wdata   = cfg_wdata[RECIP_W-1:0];
    end

    assert_enter_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && arm_code) |=> load_active);
    assert_leave_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !arm_code) |=> !load_active);
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && load_active) |=> (addr_q == $past(addr_q) + 1'b1));
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && sel == SEL_DATA && !load_active) |=> $stable(addr_q));
endmodule

// File: rtl/qz_table.sv
module qz_table #(
    parameter int NCOMP   = 3,
    parameter int BLK     = 64,
    parameter int DEPTH   = 192,
    parameter int ADDR_W  = 8,
    parameter int CW      = 2,
    parameter int ZW      = 6,
    parameter int RECIP_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [RECIP_W-1:0] wdata,
    input  logic [CW-1:0]      rd_comp,
    input  logic [ZW-1:0]      rd_idx,
    output logic [RECIP_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] BLK_L   = ADDR_W'(BLK);
    localparam logic [CW-1:0]     NCOMP_L = CW'(NCOMP);

    logic [RECIP_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0]  rd_addr;
    logic               comp_ok;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && waddr == ADDR_W'(g))
                mem[g] <= wdata;
        end
    end

    assign comp_ok = (rd_comp < NCOMP_L);
    assign rd_addr = comp_ok ? (ADDR_W'(rd_comp) * BLK_L + ADDR_W'(rd_idx)) : '0;
    assign rd_data = comp_ok ? mem[rd_addr] : '0;
endmodule

// File: rtl/qz_datapath.sv
module qz_datapath #(
    parameter int COEF_W  = 16,
    parameter int RECIP_W = 20,
    parameter int FRAC_W  = 19,
    parameter int OUT_W   = 12,
    parameter int CW      = 2,
    parameter int ZW      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_fire,
    input  logic [COEF_W-1:0]  in_coef,
    input  logic [CW-1:0]      in_comp,
    input  logic [ZW-1:0]      in_idx,
    input  logic [RECIP_W-1:0] in_recip,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_coef,
    output logic [CW-1:0]      out_comp,
    output logic [ZW-1:0]      out_idx
);
    localparam int              PROD_W  = COEF_W + RECIP_W;
    localparam logic [OUT_W-1:0] MAX_MAG = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] HALF  = PROD_W'(1) << (FRAC_W-1);

    // stage 1: magnitude, sign, reciprocal
    logic               s1_valid, s1_sign;
    logic [COEF_W-1:0]  s1_mag;
    logic [RECIP_W-1:0] s1_recip;
    logic [CW-1:0]      s1_comp;
    logic [ZW-1:0]      s1_idx;
    logic               in_sign;
    logic [COEF_W-1:0]  in_mag;

    assign in_sign = in_coef[COEF_W-1];
    assign in_mag  = in_sign ? (~in_coef + 1'b1) : in_coef;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_mag   <= '0;
            s1_recip <= '0;
            s1_comp  <= '0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= in_fire;
            if (in_fire) begin
                s1_sign  <= in_sign;
                s1_mag   <= in_mag;
                s1_recip <= in_recip;
                s1_comp  <= in_comp;
                s1_idx   <= in_idx;
            end
        end
    end

    // stage 2: multiply, round, shift, clamp, re-sign
    logic [PROD_W-1:0] prod, shifted;
    logic [OUT_W-1:0]  sat_mag, res;

    always_comb begin
        prod    = PROD_W'(s1_mag) * PROD_W'(s1_recip);
        shifted = (prod + HALF) >> FRAC_W;
        sat_mag = (shifted > PROD_W'(MAX_MAG)) ? MAX_MAG : shifted[OUT_W-1:0];
        res     = s1_sign ? (~sat_mag + 1'b1) : sat_mag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_coef  <= '0;
            out_comp  <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_coef <= res;
                out_comp <= s1_comp;
                out_idx  <= s1_idx;
            end
        end
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> ##1 out_valid);
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_coef != {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: rtl/recip_quantizer.sv
module recip_quantizer
    import qz_pkg::*;
#(
    parameter int NCOMP   = 3,
    parameter int BLK     = 64,
    parameter int COEF_W  = 16,
    parameter int RECIP_W = 20,
    parameter int FRAC_W  = 19,
    parameter int OUT_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COEF_W-1:0] in_coef,
    input  logic [1:0]        in_comp,
    input  logic [5:0]        in_idx,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_coef,
    output logic [1:0]        out_comp,
    output logic [5:0]        out_idx
);
    localparam int DEPTH  = NCOMP * BLK;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CW     = 2;
    localparam int ZW     = $clog2(BLK);

    logic               load_active, tab_we, in_fire;
    logic [ADDR_W-1:0]  tab_waddr;
    logic [RECIP_W-1:0] tab_wdata, rd_recip;

    assign in_ready = !load_active;
    assign in_fire  = in_valid && in_ready;

    qz_cfg_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RECIP_W(RECIP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .load_active(load_active), .tab_we(tab_we),
        .tab_waddr(tab_waddr), .tab_wdata(tab_wdata)
    );

    qz_table #(.NCOMP(NCOMP), .BLK(BLK), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
               .CW(CW), .ZW(ZW), .RECIP_W(RECIP_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .we(tab_we), .waddr(tab_waddr),
        .wdata(tab_wdata), .rd_comp(in_comp), .rd_idx(in_idx[ZW-1:0]),
        .rd_data(rd_recip)
    );

    qz_datapath #(.COEF_W(COEF_W), .RECIP_W(RECIP_W), .FRAC_W(FRAC_W),
                  .OUT_W(OUT_W), .CW(CW), .ZW(ZW)) u_dp (
        .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_coef(in_coef),
        .in_comp(in_comp), .in_idx(in_idx[ZW-1:0]), .in_recip(rd_recip),
        .out_valid(out_valid), .out_coef(out_coef), .out_comp(out_comp),
        .out_idx(out_idx)
    );

    assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_coef != '0) |-> (out_coef[OUT_W-1] == $past(in_coef[COEF_W-1], 2)));
    assert_stall_on_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd0 && cfg_wdata[1:0] == 2'b11) |=> !in_ready);
    assert_no_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready) |=> ##1 !out_valid);
endmodule

// File: tb/tb_recip_quantizer.sv
module tb_recip_quantizer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        in_valid, in_ready;
    logic [15:0] in_coef;
    logic [1:0]  in_comp, out_comp;
    logic [5:0]  in_idx, out_idx;
    logic        out_valid;
    logic [11:0] out_coef;

    always #2 clk = ~clk;

    recip_quantizer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .in_comp(in_comp), .in_idx(in_idx),
        .out_valid(out_valid), .out_coef(out_coef), .out_comp(out_comp),
        .out_idx(out_idx)
    );

    typedef struct { int due; int val; int comp; int idx; } exp_t;
    exp_t q[$];
    int   total = 0, bad = 0, cyc = 0;
    bit   done = 0;
    int   ref_tab[192];
    bit   model_load = 0;
    int   model_addr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int qref(int coef, int comp, int idx);
        longint r, m, v;
        r = (comp < 3) ? longint'(ref_tab[comp*64 + idx]) : 0;   // R9
        m = (coef < 0) ? -longint'(coef) : longint'(coef);
        v = (m * r + 262144) >>> 19;                              // R5
        if (v > 2047) v = 2047;                                   // R6
        return (coef < 0) ? -int'(v) : int'(v);
    endfunction

    function automatic int lstep(int i);
        return (i == 0) ? 1 : (i == 1) ? 2 : 3 + (i*5) % 60;
    endfunction
    function automatic int cstep(int i);
        return 2 + (i*11) % 90;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            #1;
            total++;
            if (in_ready !== !model_load) begin
                bad++;
                $display("FAIL R8 in_ready=%0b expected=%0b at cycle %0d", in_ready, !model_load, cyc);
            end
            total++;
            if (q.size() > 0 && q[0].due == cyc) begin
                if (out_valid !== 1'b1 || int'($signed(out_coef)) != q[0].val ||
                    int'(out_comp) != q[0].comp || int'(out_idx) != q[0].idx) begin
                    bad++;
                    $display("FAIL R5 R7 valid=%0b coef=%0d comp=%0d idx=%0d expected coef=%0d comp=%0d idx=%0d",
                             out_valid, $signed(out_coef), out_comp, out_idx, q[0].val, q[0].comp, q[0].idx);
                end
                void'(q.pop_front());
            end else if (out_valid !== 1'b0) begin
                bad++;
                $display("FAIL R7 out_valid=%0b expected=0 at cycle %0d", out_valid, cyc);
            end
        end
    end

    task automatic cfg_write(int sel, int data);
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) model_load = (data[1:0] == 2'b11);          // R1
        else if (sel == 1) model_addr = data & 255;               // R2
        else if (sel == 2 && model_load) begin                    // R3, R4
            if (model_addr < 192) ref_tab[model_addr] = data & 20'hFFFFF;
            model_addr = (model_addr + 1) & 255;
        end
    endtask

    task automatic send(int coef, int comp, int idx);
        exp_t e;
        in_valid = 1'b1; in_coef = coef[15:0]; in_comp = comp[1:0]; in_idx = idx[5:0];
        if (in_ready === 1'b1) begin
            e.due = cyc + 2; e.val = qref(coef, comp, idx); e.comp = comp; e.idx = idx;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_ready(logic exp, string tag);
        total++;
        if (in_ready !== exp) begin
            bad++;
            $display("FAIL %s in_ready=%0b expected=%0b", tag, in_ready, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired, queue=%0d expected=0", q.size());
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        in_valid = 0; in_coef = 0; in_comp = 0; in_idx = 0;
        for (int i = 0; i < 192; i++) ref_tab[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        total++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            bad++;
            $display("FAIL R10 out_valid=%0b in_ready=%0b expected 0 and 1", out_valid, in_ready);
        end
        // R10: empty table gives zero
        send(1000, 0, 5); send(-700, 2, 63);
        idle(3);

        // R1 arm, R8 stall while loading, R2/R3 load luma
        cfg_write(0, (0 << 6) | 3);
        check_ready(1'b0, "R1");
        send(50, 0, 0);
        cfg_write(1, 0);
        for (int i = 0; i < 64; i++) cfg_write(2, 524288 / lstep(i));
        cfg_write(0, (1 << 6) | 3);
        cfg_write(1, 64);
        for (int i = 0; i < 64; i++) cfg_write(2, 524288 / cstep(i));
        cfg_write(0, (2 << 6) | 3);
        cfg_write(1, 128);
        for (int i = 0; i < 64; i++) cfg_write(2, 524288 / cstep(i));
        cfg_write(3, 77);   // R4: no effect
        cfg_write(0, 0);
        check_ready(1'b1, "R1");
        idle(2);

        // R4: data write outside load mode is dropped
        cfg_write(1, 0);
        cfg_write(2, 12345);
        send(500, 0, 0);
        idle(3);

        // R3: top edge of the table
        cfg_write(0, 3);
        cfg_write(1, 190);
        cfg_write(2, 1000); cfg_write(2, 2000); cfg_write(2, 3000);
        cfg_write(0, 0);
        send(1000, 2, 62); send(1000, 2, 63); send(1000, 2, 61); send(1000, 0, 0);
        idle(3);

        // R5 rounding with step 2 at comp0 idx1
        send(3, 0, 1); send(-3, 0, 1); send(1, 0, 1); send(-1, 0, 1);
        send(2, 0, 1); send(0, 0, 1); send(-2, 0, 1);
        idle(2);
        // R6 saturation with step 1 at comp0 idx0
        send(30000, 0, 0); send(-32768, 0, 0); send(2047, 0, 0);
        send(-2048, 0, 0); send(2048, 0, 0); send(-2047, 0, 0);
        idle(2);
        // R9 component 3
        send(1000, 3, 10); send(-32768, 3, 0);
        idle(3);

        // R7 mixed stream with gaps
        seed = 7;
        for (int n = 0; n < 400; n++) begin
            seed = seed * 1103515245 + 12345;
            send(((seed >>> 8) % 20000) - 10000 + ((seed & 1) ? 0 : 0),
                 (seed >>> 4) & 3, (seed >>> 12) & 63);
            if (((seed >>> 20) & 7) == 0) idle(1);
        end
        idle(5);

        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R7 pending=%0d expected=0", q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule